// File: doc/BRIEF.md
# Internal RC Oscillator Controller

This block wraps the digital side of an on-chip RC oscillator. A software enable request, or a latched external-crystal failure, turns the oscillator on. A settle counter running on the oscillator's own clock decides when the oscillator is stable. That indication is synchronised into the system clock domain, where it raises a ready flag. Software cannot write the ready flag. The oscillator clock reaches its consumers only through a gate. The gate opens after ready is set and it only changes state while the oscillator clock is low.

A factory calibration byte is captured from a fixed fuse input on the first system clock edge after reset. It is then held as a read-only value. A separate 5-bit user trim register defaults to its midpoint. The two are added, the trim taken relative to that midpoint, and the result is saturated to form the 8-bit trim code driven to the analog oscillator. The trim register can be rewritten while the oscillator is running. When the crystal-fail input pulses, a backup flag latches and keeps the oscillator enabled until the next reset, whatever the software bit says.

A four-state machine in the system domain sequences the oscillator:
- States: `ST_OFF` (disabled), `ST_WAIT` (enabled, settling), `ST_RUN` (ready) and `ST_DRAIN` (disabled, waiting for the stable indication to clear).
- Transitions:
  - `ST_OFF` goes to `ST_WAIT` when enable is requested.
  - `ST_WAIT` goes to `ST_RUN` when stability is seen.
  - `ST_WAIT` or `ST_RUN` goes to `ST_DRAIN` when the request drops.
  - `ST_DRAIN` goes to `ST_OFF` once the synchronised stable indication is low. A new enable request therefore always restarts the settle count from zero.

Top module: `rcosc_ctrl`

## Requirements
- R1: When the enable request (`sw_en_i` or `backup_o`) is sampled high in `ST_OFF`, `osc_en_o` is high after that clock edge. When the request is sampled low, `osc_en_o` is low after that edge.
- R2: `ready_o` rises only after at least `SETTLE_CYCLES` rising edges of `osc_clk_i` have occurred with `osc_en_o` high. It rises no later than `SYNC_STAGES`+2 system cycles after that count completes. `ready_o` is never high while `osc_en_o` is low.
- R3: `ready_o` is low after the first system clock edge at which the enable request is sampled low, which is well within two system cycles.
- R4: `clk_o` stays low until `ready_o` has been set, and then follows `osc_clk_i`. After `ready_o` falls, `clk_o` stops within a few oscillator cycles. The gate changes state only on falling edges of `osc_clk_i`.
- R5: `cal_o` takes the value of `cal_fuse_i` at the first system clock edge after reset release. Later changes of `cal_fuse_i` have no effect until the next reset.
- R6: `trim_o` resets to 16. A cycle with `trim_wr_i` high loads `trim_wdata_i`, which is visible in `trim_o` after that edge.
- R7: `trim_code_o` equals `cal_o + trim_o - 16`, clamped to the range 0 to 255.
- R8: A trim write while the oscillator is running and requested leaves `osc_en_o` and `ready_o` high.
- R9: A high cycle on `xtal_fail_i` sets `backup_o`. `backup_o` holds the oscillator requested regardless of `sw_en_i`, and only reset clears it.
- R10: During and right after reset, `osc_en_o`, `ready_o`, `backup_o` and `clk_o` are low, and `trim_o` is 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| osc_clk_i | input | 1 | Raw RC oscillator clock |
| sw_en_i | input | 1 | Software enable bit |
| trim_wr_i | input | 1 | Trim register write strobe |
| trim_wdata_i | input | 5 | Trim value to write |
| cal_fuse_i | input | 8 | Fixed factory calibration source |
| xtal_fail_i | input | 1 | External crystal failure indication |
| osc_en_o | output | 1 | Enable to the analog oscillator |
| ready_o | output | 1 | Hardware-set oscillator ready flag |
| backup_o | output | 1 | Backup (forced-on) mode latched |
| clk_o | output | 1 | Gated oscillator clock to consumers |
| cal_o | output | 8 | Captured calibration value, read-only |
| trim_o | output | 5 | Current user trim value |
| trim_code_o | output | 8 | Combined trim code to the oscillator |

## Verification
The trim path is driven with random fuse values and random trim writes, and each is compared with a bench model of the clamped sum. Directed fuse and trim pairs at both saturation limits tell clamping apart from plain wraparound. The enable path is driven by software enable, disable and backup-triggered enables. Oscillator edges and gated-clock edges are counted against `ready_o`, which separates an early or late ready from a gate that opens before ready or stays open after disable. Toggling `sw_en_i` while backup is latched shows whether the forced path really overrides software.

// File: rtl/rcosc_pkg.sv
package rcosc_pkg;

    localparam int CAL_W    = 8;
    localparam int TRIM_W   = 5;
    localparam int TRIM_MID = 1 << (TRIM_W - 1);
    localparam int CAL_MAX  = (1 << CAL_W) - 1;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WAIT  = 2'd1,
        ST_RUN   = 2'd2,
        ST_DRAIN = 2'd3
    } rcosc_state_e;

    // Calibration plus trim offset from midpoint, saturated to the code range.
    function automatic logic [CAL_W-1:0] trim_combine(input logic [CAL_W-1:0]  cal,
                                                      input logic [TRIM_W-1:0] trim);
        int sum;
        sum = int'(cal) + int'(trim) - TRIM_MID;
        if (sum < 0) begin
            return '0;
        end else if (sum > CAL_MAX) begin
            return '1;
        end else begin
            return sum[CAL_W-1:0];
        end
    endfunction

endpackage

// File: rtl/rcosc_sync.sv
module rcosc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    chain_q[s] <= 1'b0;
                end else if (s == 0) begin
                    chain_q[s] <= d_i;
                end else begin
                    chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rcosc_settle.sv
module rcosc_settle #(
    parameter int SETTLE_CYCLES = 16
) (
    input  logic osc_clk_i,
    input  logic rst_ni,
    input  logic osc_en_i,
    output logic stable_o
);

    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

    logic             clr_n;
    logic [CNT_W-1:0] cnt_q;
    logic             stable_q;

    // Counter is held clear whenever the oscillator is not enabled.
    assign clr_n = rst_ni & osc_en_i;

    always_ff @(posedge osc_clk_i or negedge clr_n) begin
        if (!clr_n) begin
            cnt_q    <= '0;
            stable_q <= 1'b0;
        end else if (!stable_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
                stable_q <= 1'b1;
            end
        end
    end

    assign stable_o = stable_q;

endmodule

// File: rtl/rcosc_gate.sv
module rcosc_gate #(
    parameter int STAGES = 2
) (
    input  logic osc_clk_i,
    input  logic rst_ni,
    input  logic open_i,
    output logic clk_o
);

    logic [STAGES-1:0] open_q;

    // All gate state moves on the falling edge, while the clock is low.
    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(negedge osc_clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    open_q[s] <= 1'b0;
                end else if (s == 0) begin
                    open_q[s] <= open_i;
                end else begin
                    open_q[s] <= open_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign clk_o = osc_clk_i & open_q[STAGES-1];

endmodule

// File: rtl/rcosc_trim.sv
module rcosc_trim
    import rcosc_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CAL_W-1:0]  cal_fuse_i,
    input  logic              trim_wr_i,
    input  logic [TRIM_W-1:0] trim_wdata_i,
    output logic [CAL_W-1:0]  cal_o,
    output logic [TRIM_W-1:0] trim_o,
    output logic [CAL_W-1:0]  trim_code_o
);

    logic [CAL_W-1:0]  cal_q;
    logic              cal_loaded_q;
    logic [TRIM_W-1:0] trim_q;

    // Calibration is captured once, on the first edge after reset.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cal_q        <= '0;
            cal_loaded_q <= 1'b0;
        end else if (!cal_loaded_q) begin
            cal_q        <= cal_fuse_i;
            cal_loaded_q <= 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            trim_q <= TRIM_W'(TRIM_MID);
        end else if (trim_wr_i) begin
            trim_q <= trim_wdata_i;
        end
    end

    assign cal_o       = cal_q;
    assign trim_o      = trim_q;
    assign trim_code_o = trim_combine(cal_q, trim_q);

endmodule

// File: rtl/rcosc_ctrl.sv
module rcosc_ctrl
    import rcosc_pkg::*;
#(
    parameter int SETTLE_CYCLES = 16,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              osc_clk_i,
    input  logic              sw_en_i,
    input  logic              trim_wr_i,
    input  logic [TRIM_W-1:0] trim_wdata_i,
    input  logic [CAL_W-1:0]  cal_fuse_i,
    input  logic              xtal_fail_i,
    output logic              osc_en_o,
    output logic              ready_o,
    output logic              backup_o,
    output logic              clk_o,
    output logic [CAL_W-1:0]  cal_o,
    output logic [TRIM_W-1:0] trim_o,
    output logic [CAL_W-1:0]  trim_code_o
);

    rcosc_state_e state_q, state_d;
    logic         fail_q;
    logic         en_req;
    logic         stable_osc;
    logic         stable_sys;

    // Crystal failure latch: only reset clears it.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fail_q <= 1'b0;
        end else if (xtal_fail_i) begin
            fail_q <= 1'b1;
        end
    end

    assign en_req = sw_en_i | fail_q;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (en_req) state_d = ST_WAIT;
            ST_WAIT:  begin
                if (!en_req)         state_d = ST_DRAIN;
                else if (stable_sys) state_d = ST_RUN;
            end
            ST_RUN:   if (!en_req) state_d = ST_DRAIN;
            ST_DRAIN: if (!stable_sys) state_d = ST_OFF;
            default:  state_d = ST_OFF;
        endcase
    end

    // Outputs decoded from the state register
    always_comb begin
        osc_en_o = 1'b0;
        ready_o  = 1'b0;
        unique case (state_q)
            ST_OFF:   ;
            ST_WAIT:  osc_en_o = 1'b1;
            ST_RUN:   begin
                osc_en_o = 1'b1;
                ready_o  = 1'b1;
            end
            ST_DRAIN: ;
            default:  ;
        endcase
    end

    assign backup_o = fail_q;

    rcosc_settle #(
        .SETTLE_CYCLES(SETTLE_CYCLES)
    ) u_settle (
        .osc_clk_i(osc_clk_i),
        .rst_ni   (rst_ni),
        .osc_en_i (osc_en_o),
        .stable_o (stable_osc)
    );

    rcosc_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (stable_osc),
        .q_o   (stable_sys)
    );

    rcosc_gate #(
        .STAGES(SYNC_STAGES)
    ) u_gate (
        .osc_clk_i(osc_clk_i),
        .rst_ni   (rst_ni),
        .open_i   (ready_o),
        .clk_o    (clk_o)
    );

    rcosc_trim u_trim (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cal_fuse_i  (cal_fuse_i),
        .trim_wr_i   (trim_wr_i),
        .trim_wdata_i(trim_wdata_i),
        .cal_o       (cal_o),
        .trim_o      (trim_o),
        .trim_code_o (trim_code_o)
    );

endmodule

// File: rtl/rcosc_ctrl_chk.sv
module rcosc_ctrl_chk
    import rcosc_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              sw_en_i,
    input logic              trim_wr_i,
    input logic [TRIM_W-1:0] trim_wdata_i,
    input logic              osc_en_o,
    input logic              ready_o,
    input logic              backup_o,
    input logic [CAL_W-1:0]  cal_o,
    input logic [TRIM_W-1:0] trim_o
);

    logic [1:0] age_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    // R1
    dis_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sw_en_i && !backup_o) |=> !osc_en_o);

    // R2
    rdy_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o |-> osc_en_o);

    // R3
    rdy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sw_en_i && !backup_o) |=> !ready_o);

    // R5
    cal_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q >= 2'd2) |-> $stable(cal_o));

    // R6
    trim_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trim_wr_i |=> (trim_o == $past(trim_wdata_i)));

    // R8
    trim_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trim_wr_i && ready_o && (sw_en_i || backup_o)) |=> ready_o);

    // R9
    backup_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        backup_o |=> backup_o);

endmodule

bind rcosc_ctrl rcosc_ctrl_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sw_en_i     (sw_en_i),
    .trim_wr_i   (trim_wr_i),
    .trim_wdata_i(trim_wdata_i),
    .osc_en_o    (osc_en_o),
    .ready_o     (ready_o),
    .backup_o    (backup_o),
    .cal_o       (cal_o),
    .trim_o      (trim_o)
);

// File: tb/rcosc_ctrl_tb_top.sv
`timescale 1ns/100ps
module rcosc_ctrl_tb_top;

    localparam int SETTLE = 16;

    logic       clk = 1'b0;
    logic       osc = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_en = 1'b0;
    logic       trim_wr = 1'b0;
    logic [4:0] trim_wdata = '0;
    logic [7:0] fuse = '0;
    logic       xfail = 1'b0;
    logic       osc_en, ready, backup, gclk;
    logic [7:0] cal, code;
    logic [4:0] trim;

    int n_chk = 0;
    int n_bad = 0;
    int osc_cnt = 0;
    int gate_cnt = 0;

    always #2 clk = ~clk;
    always #3.1 osc = ~osc;

    rcosc_ctrl #(.SETTLE_CYCLES(SETTLE), .SYNC_STAGES(2)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .osc_clk_i(osc), .sw_en_i(sw_en),
        .trim_wr_i(trim_wr), .trim_wdata_i(trim_wdata), .cal_fuse_i(fuse),
        .xtal_fail_i(xfail), .osc_en_o(osc_en), .ready_o(ready),
        .backup_o(backup), .clk_o(gclk), .cal_o(cal), .trim_o(trim),
        .trim_code_o(code)
    );

    always @(posedge osc) begin
        if (osc_en) osc_cnt = osc_cnt + 1;
        else        osc_cnt = 0;
    end

    always @(posedge gclk) gate_cnt = gate_cnt + 1;

    function automatic int exp_code(input int c, input int t);
        int v;
        v = c + t - 16;
        if (v < 0) v = 0;
        if (v > 255) v = 255;
        return v;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [7:0] f);
        @(negedge clk);
        rst_n = 1'b0;
        sw_en = 1'b0;
        xfail = 1'b0;
        trim_wr = 1'b0;
        fuse = f;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic write_trim(input logic [4:0] v);
        trim_wr = 1'b1;
        trim_wdata = v;
        @(negedge clk);
        trim_wr = 1'b0;
    endtask

    task automatic wait_ready(input string req);
        int cycles = 0;
        while (!ready && cycles < 200) begin
            @(negedge clk);
            cycles++;
        end
        check(req, int'(ready), 1);
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seen;
        void'($urandom(32'h1c0ffee));

        // R10 reset state
        rst_n = 1'b0;
        fuse = 8'h80;
        repeat (2) @(negedge clk);
        gate_cnt = 0;
        check("R10 osc_en in reset", int'(osc_en), 0);
        check("R10 ready in reset", int'(ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 backup", int'(backup), 0);
        check("R10 trim default", int'(trim), 16);
        check("R5 cal captured", int'(cal), 8'h80);
        check("R7 code at default trim", int'(code), 8'h80);
        repeat (10) @(negedge clk);
        check("R10 clk_o quiet", gate_cnt, 0);

        // R5 later fuse changes ignored
        fuse = 8'h11;
        repeat (3) @(negedge clk);
        check("R5 cal frozen", int'(cal), 8'h80);

        // R1 enable, R2 settle, R4 gate
        gate_cnt = 0;
        sw_en = 1'b1;
        @(negedge clk);
        check("R1 osc_en rises", int'(osc_en), 1);
        check("R2 not ready yet", int'(ready), 0);
        wait_ready("R2 ready sets");
        seen = osc_cnt;
        check("R2 settle lower bound", int'(seen >= SETTLE), 1);
        check("R2 settle upper bound", int'(seen <= SETTLE + 4), 1);
        check("R4 gate closed before ready", gate_cnt, 0);
        repeat (20) @(negedge clk);
        check("R4 gate passes clock", int'(gate_cnt > 5), 1);

        // R8 trim writes while running, R6 and R7 values
        for (int i = 0; i < 6; i++) begin
            logic [4:0] tv;
            tv = 5'($urandom_range(0, 31));
            write_trim(tv);
            check("R8 ready kept", int'(ready), 1);
            check("R8 osc_en kept", int'(osc_en), 1);
            check("R6 trim loaded", int'(trim), int'(tv));
            check("R7 code", int'(code), exp_code(8'h80, int'(tv)));
        end

        // R1 and R3 disable
        sw_en = 1'b0;
        @(negedge clk);
        check("R1 osc_en falls", int'(osc_en), 0);
        check("R3 ready falls", int'(ready), 0);
        repeat (6) @(negedge clk);
        gate_cnt = 0;
        repeat (10) @(negedge clk);
        check("R4 gate closed after disable", gate_cnt, 0);

        // R6 and R7 random fuse and trim
        for (int r = 0; r < 6; r++) begin
            logic [7:0] fv;
            fv = 8'($urandom_range(0, 255));
            do_reset(fv);
            check("R5 cal random", int'(cal), int'(fv));
            check("R6 trim reset", int'(trim), 16);
            for (int k = 0; k < 8; k++) begin
                logic [4:0] tv;
                tv = 5'($urandom_range(0, 31));
                write_trim(tv);
                check("R6 trim random", int'(trim), int'(tv));
                check("R7 code random", int'(code), exp_code(int'(fv), int'(tv)));
            end
        end

        // R7 saturation corners
        do_reset(8'h00);
        write_trim(5'd0);
        check("R7 clamp low", int'(code), 0);
        write_trim(5'd31);
        check("R7 low fuse high trim", int'(code), 15);
        do_reset(8'hFF);
        write_trim(5'd31);
        check("R7 clamp high", int'(code), 255);
        write_trim(5'd0);
        check("R7 high fuse low trim", int'(code), 239);
        do_reset(8'h03);
        write_trim(5'd10);
        check("R7 negative sum", int'(code), 0);

        // R9 backup path
        do_reset(8'h40);
        xfail = 1'b1;
        @(negedge clk);
        xfail = 1'b0;
        check("R9 backup latched", int'(backup), 1);
        @(negedge clk);
        check("R9 forced enable", int'(osc_en), 1);
        wait_ready("R9 ready under backup");
        sw_en = 1'b1;
        repeat (3) @(negedge clk);
        sw_en = 1'b0;
        repeat (5) @(negedge clk);
        check("R9 sw_en ignored ready", int'(ready), 1);
        check("R9 sw_en ignored osc_en", int'(osc_en), 1);
        check("R9 backup holds", int'(backup), 1);
        do_reset(8'h40);
        check("R9 reset clears backup", int'(backup), 0);
        check("R9 off after reset", int'(osc_en), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule